// File: doc/BRIEF.md
# Settable Seconds Countdown Alarm

This block is the control core of a small countdown alarm for a two-digit display. The user picks a start value between 1 and 59 seconds with single-cycle key pulses. The enter key then starts a countdown that moves down by one second on each 1 Hz tick. When the count runs out, the display holds "00" and flashes at 1 Hz. The set key returns the block to setting mode. The key pulses are assumed to be debounced already. Both ticks are one-cycle strobes in the block's own clock domain. The outputs are two BCD digits, a blank strobe that drives the flashing, and a flag that shows whether the block is in setting mode. Segment decoding and display multiplexing are done outside this block.

Inside, a three-state machine steps through SETUP, RUN and EXPIRED. It has five named transitions:

- START goes from SETUP to RUN on enter.
- STOP goes from RUN to SETUP on set.
- TIMEOUT goes from RUN to EXPIRED on a 1 Hz tick while the count is at 01.
- ACK goes from EXPIRED to SETUP on set.
- RESET forces SETUP from any state.

In every other case each state holds. The start value lives in a BCD preset register. The running value lives in a separate BCD down counter. A blink toggle is driven by the 2 Hz phase tick.

Top module: `cdown_alarm_top`

## Requirements
- R1: After reset, and after any later reset, the block is in SETUP: mode_setting is 1, the digits show 0 and 1 (start value 01), and blank is 0.
- R2: In SETUP, each key_up adds one to the start value in BCD, carrying from ones into tens (09 becomes 10). From 59 it wraps to 01, so the value always stays within 1 to 59.
- R3: In SETUP, each key_down subtracts one in BCD, borrowing from tens (10 becomes 09). From 01 it wraps to 59. If up and down arrive together, up wins.
- R4: key_enter in SETUP loads the counter with the start value and moves to RUN. From the next cycle mode_setting is 0 and the digits show the same value.
- R5: In RUN, each tick_1hz decrements the displayed count by one in BCD, with a borrow from tens (10 becomes 09).
- R6: The tick_1hz that finds the count at 01 moves to EXPIRED. The digits then read 00 with blank at 0. After that, blank inverts on every tick_2hz, and the state holds until key_set.
- R7: key_set in RUN or EXPIRED moves to SETUP. From the next cycle blank is 0 and the digits show the retained start value.
- R8: key_set in SETUP has no effect: the mode and the digits are unchanged.
- R9: Outside SETUP, key_enter, key_up and key_down are ignored. tick_1hz is ignored in SETUP and EXPIRED. tick_2hz has no effect outside EXPIRED.
- R10: A key_set that arrives in the same cycle as the final tick_1hz in RUN takes priority. The block goes to SETUP with blank 0, and EXPIRED is never entered.
- R11: A key_enter in SETUP takes priority over a key_up or key_down in the same cycle. The start value is not changed, and the count starts from the value shown before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| tick_2hz | input | 1 | One-cycle strobe, twice per second, used as the flash phase |
| key_set | input | 1 | Set key pulse |
| key_up | input | 1 | Up key pulse |
| key_down | input | 1 | Down key pulse |
| key_enter | input | 1 | Enter key pulse |
| digit_tens | output | 4 | BCD tens digit shown on the display |
| digit_ones | output | 4 | BCD ones digit shown on the display |
| blank | output | 1 | 1 turns the display off (flash phase) |
| mode_setting | output | 1 | 1 in SETUP, 0 in RUN or EXPIRED |

## Verification
Two cases can fall in the same cycle and need an arbiter.

The first is the key_set that stops the countdown arriving together with the 1 Hz tick that would have caused TIMEOUT. The bench starts a count from 01 and drives key_set and tick_1hz in the same cycle. It passes only if the next cycle shows SETUP with blank low and the retained start value, with no sign of EXPIRED.

The second is enter arriving together with up in SETUP. The bench judges it by checking that the count starts from the value shown before that cycle, and that the start value reads back unchanged after STOP.

// File: rtl/cdown_pkg.sv
package cdown_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        ST_SETUP   = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } cd_state_t;

endpackage

// File: rtl/cd_preset.sv
module cd_preset #(
    parameter int MIN_SEC = 1,
    parameter int MAX_SEC = 59,
    parameter int DW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [DW-1:0] tens,
    output logic [DW-1:0] ones
);
    localparam logic [DW-1:0] MIN_T = DW'(MIN_SEC / 10);
    localparam logic [DW-1:0] MIN_O = DW'(MIN_SEC % 10);
    localparam logic [DW-1:0] MAX_T = DW'(MAX_SEC / 10);
    localparam logic [DW-1:0] MAX_O = DW'(MAX_SEC % 10);
    localparam logic [DW-1:0] NINE  = DW'(9);

    logic at_max, at_min;
    assign at_max = (tens == MAX_T) && (ones == MAX_O);
    assign at_min = (tens == MIN_T) && (ones == MIN_O);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tens <= MIN_T;
            ones <= MIN_O;
        end else if (inc) begin
            if (at_max) begin
                tens <= MIN_T;
                ones <= MIN_O;
            end else if (ones == NINE) begin
                tens <= tens + 1'b1;
                ones <= '0;
            end else begin
                ones <= ones + 1'b1;
            end
        end else if (dec) begin
            if (at_min) begin
                tens <= MAX_T;
                ones <= MAX_O;
            end else if (ones == '0) begin
                tens <= tens - 1'b1;
                ones <= NINE;
            end else begin
                ones <= ones - 1'b1;
            end
        end
    end
endmodule

// File: rtl/cd_counter.sv
module cd_counter #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_tens,
    input  logic [DW-1:0] load_ones,
    input  logic          dec,
    output logic [DW-1:0] tens,
    output logic [DW-1:0] ones,
    output logic          at_last
);
    localparam logic [DW-1:0] NINE = DW'(9);

    assign at_last = (tens == '0) && (ones == DW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tens <= '0;
            ones <= '0;
        end else if (load) begin
            tens <= load_tens;
            ones <= load_ones;
        end else if (dec) begin
            if (ones == '0) begin
                tens <= tens - 1'b1;
                ones <= NINE;
            end else begin
                ones <= ones - 1'b1;
            end
        end
    end
endmodule

// File: rtl/cd_blink.sv
module cd_blink (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic phase_tick,
    output logic blank_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          blank_q <= 1'b0;
        else if (!en)        blank_q <= 1'b0;
        else if (phase_tick) blank_q <= ~blank_q;
    end
endmodule

// File: rtl/cd_fsm.sv
module cd_fsm
    import cdown_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      key_set,
    input  logic      key_up,
    input  logic      key_down,
    input  logic      key_enter,
    input  logic      tick_1hz,
    input  logic      cnt_last,
    output cd_state_t state,
    output logic      preset_inc,
    output logic      preset_dec,
    output logic      cnt_load,
    output logic      cnt_dec
);
    cd_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SETUP;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SETUP:   if (key_enter) state_nx = ST_RUN;                       // START
            ST_RUN:     if (key_set) state_nx = ST_SETUP;                       // STOP
                        else if (tick_1hz && cnt_last) state_nx = ST_EXPIRED;  // TIMEOUT
            ST_EXPIRED: if (key_set) state_nx = ST_SETUP;                       // ACK
            default:    state_nx = ST_SETUP;
        endcase
    end

    always_comb begin
        preset_inc = 1'b0;
        preset_dec = 1'b0;
        cnt_load   = 1'b0;
        cnt_dec    = 1'b0;
        unique case (state)
            ST_SETUP: begin
                cnt_load   = key_enter;
                preset_inc = key_up && !key_enter;
                preset_dec = key_down && !key_up && !key_enter;
            end
            ST_RUN:     cnt_dec = tick_1hz && !key_set;
            ST_EXPIRED: ;
            default:    ;
        endcase
    end
endmodule

// File: rtl/cdown_alarm_top.sv
module cdown_alarm_top
    import cdown_pkg::*;
#(
    parameter int MIN_SEC = 1,
    parameter int MAX_SEC = 59
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_1hz,
    input  logic               tick_2hz,
    input  logic               key_set,
    input  logic               key_up,
    input  logic               key_down,
    input  logic               key_enter,
    output logic [DIGIT_W-1:0] digit_tens,
    output logic [DIGIT_W-1:0] digit_ones,
    output logic               blank,
    output logic               mode_setting
);
    cd_state_t          state;
    logic               preset_inc, preset_dec, cnt_load, cnt_dec, cnt_last;
    logic               blank_q;
    logic [DIGIT_W-1:0] pre_tens, pre_ones, cnt_tens, cnt_ones;

    cd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .key_set(key_set), .key_up(key_up), .key_down(key_down),
        .key_enter(key_enter), .tick_1hz(tick_1hz), .cnt_last(cnt_last),
        .state(state), .preset_inc(preset_inc), .preset_dec(preset_dec),
        .cnt_load(cnt_load), .cnt_dec(cnt_dec)
    );

    cd_preset #(.MIN_SEC(MIN_SEC), .MAX_SEC(MAX_SEC), .DW(DIGIT_W)) u_preset (
        .clk(clk), .rst_n(rst_n), .inc(preset_inc), .dec(preset_dec),
        .tens(pre_tens), .ones(pre_ones)
    );

    cd_counter #(.DW(DIGIT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .load(cnt_load),
        .load_tens(pre_tens), .load_ones(pre_ones), .dec(cnt_dec),
        .tens(cnt_tens), .ones(cnt_ones), .at_last(cnt_last)
    );

    cd_blink u_blink (
        .clk(clk), .rst_n(rst_n), .en(state == ST_EXPIRED),
        .phase_tick(tick_2hz), .blank_q(blank_q)
    );

    always_comb begin
        mode_setting = (state == ST_SETUP);
        blank        = blank_q && (state == ST_EXPIRED);
        if (state == ST_SETUP) begin
            digit_tens = pre_tens;
            digit_ones = pre_ones;
        end else begin
            digit_tens = cnt_tens;
            digit_ones = cnt_ones;
        end
    end
endmodule

// File: rtl/cdown_alarm_chk.sv
module cdown_alarm_chk #(
    parameter int MIN_SEC = 1,
    parameter int MAX_SEC = 59
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic       tick_2hz,
    input logic       key_set,
    input logic       key_up,
    input logic       key_down,
    input logic       key_enter,
    input logic [3:0] digit_tens,
    input logic [3:0] digit_ones,
    input logic       blank,
    input logic       mode_setting
);
    AST_PRESET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_setting |-> (digit_ones <= 4'd9) &&
        (int'(digit_tens) * 10 + int'(digit_ones) >= MIN_SEC) &&
        (int'(digit_tens) * 10 + int'(digit_ones) <= MAX_SEC));  // R2

    AST_EXPIRED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> !mode_setting && digit_tens == 4'd0 && digit_ones == 4'd0);  // R6

    AST_ENTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_setting && key_enter |=> !mode_setting && !blank &&
        $stable(digit_tens) && $stable(digit_ones));  // R4

    AST_SET_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_setting && key_set |=> mode_setting && !blank);  // R7

    AST_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_setting && key_set && !key_up && !key_down && !key_enter |=>
        mode_setting && $stable(digit_tens) && $stable(digit_ones));  // R8

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_setting && !key_set && !tick_1hz |=>
        !mode_setting && $stable(digit_tens) && $stable(digit_ones));  // R9
endmodule

bind cdown_alarm_top cdown_alarm_chk #(.MIN_SEC(MIN_SEC), .MAX_SEC(MAX_SEC)) u_chk (.*);

// File: tb/tb_cdown_alarm_top.sv
module tb_cdown_alarm_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0, tick_2hz = 1'b0;
    logic       key_set = 1'b0, key_up = 1'b0, key_down = 1'b0, key_enter = 1'b0;
    logic [3:0] digit_tens, digit_ones;
    logic       blank, mode_setting;
    int         n_vec = 0;
    int         n_bad = 0;

    always #5 clk = ~clk;

    cdown_alarm_top dut (.*);

    // vector: {set,up,down,enter}, {t1,t2}, tens, ones, mode_setting, blank
    localparam int NV = 18;
    localparam logic [15:0] VEC [NV] = '{
        {4'b0100, 2'b00, 4'd0, 4'd2, 1'b1, 1'b0},  // R2 up 01->02
        {4'b0010, 2'b00, 4'd0, 4'd1, 1'b1, 1'b0},  // R3 down 02->01
        {4'b0010, 2'b00, 4'd5, 4'd9, 1'b1, 1'b0},  // R3 wrap 01->59
        {4'b0100, 2'b00, 4'd0, 4'd1, 1'b1, 1'b0},  // R2 wrap 59->01
        {4'b0110, 2'b00, 4'd0, 4'd2, 1'b1, 1'b0},  // R3 up beats down
        {4'b1000, 2'b00, 4'd0, 4'd2, 1'b1, 1'b0},  // R8 set in setup
        {4'b0000, 2'b10, 4'd0, 4'd2, 1'b1, 1'b0},  // R9 tick ignored in setup
        {4'b0001, 2'b00, 4'd0, 4'd2, 1'b0, 1'b0},  // R4 enter starts
        {4'b0100, 2'b00, 4'd0, 4'd2, 1'b0, 1'b0},  // R9 up ignored
        {4'b0011, 2'b00, 4'd0, 4'd2, 1'b0, 1'b0},  // R9 enter/down ignored
        {4'b0000, 2'b10, 4'd0, 4'd1, 1'b0, 1'b0},  // R5 tick 02->01
        {4'b0000, 2'b01, 4'd0, 4'd1, 1'b0, 1'b0},  // R9 2 Hz ignored in run
        {4'b0000, 2'b10, 4'd0, 4'd0, 1'b0, 1'b0},  // R6 expire, unblanked
        {4'b0000, 2'b01, 4'd0, 4'd0, 1'b0, 1'b1},  // R6 blank on
        {4'b0001, 2'b10, 4'd0, 4'd0, 1'b0, 1'b1},  // R9 enter/tick ignored
        {4'b0000, 2'b01, 4'd0, 4'd0, 1'b0, 1'b0},  // R6 blank off
        {4'b1000, 2'b00, 4'd0, 4'd2, 1'b1, 1'b0},  // R7 set leaves expired
        {4'b0100, 2'b00, 4'd0, 4'd3, 1'b1, 1'b0}   // R2 preset retained
    };

    task automatic check(string req, logic [3:0] et, logic [3:0] eo, logic em, logic eb);
        n_vec++;
        if (digit_tens !== et || digit_ones !== eo || mode_setting !== em || blank !== eb) begin
            n_bad++;
            $display("FAIL %s: got %0d%0d mode=%0b blank=%0b, expected %0d%0d mode=%0b blank=%0b",
                     req, digit_tens, digit_ones, mode_setting, blank, et, eo, em, eb);
        end
    endtask

    task automatic apply(logic [3:0] keys, logic [1:0] ticks);
        @(negedge clk);
        {key_set, key_up, key_down, key_enter} = keys;
        {tick_1hz, tick_2hz} = ticks;
        @(negedge clk);
        {key_set, key_up, key_down, key_enter} = 4'b0;
        {tick_1hz, tick_2hz} = 2'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", 4'd0, 4'd1, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][15:12], VEC[i][11:10]);
            check($sformatf("vector %0d", i), VEC[i][9:6], VEC[i][5:2], VEC[i][1], VEC[i][0]);
        end

        // preset is 03: BCD carry and borrow (R2, R3, R5)
        for (int i = 0; i < 7; i++) apply(4'b0100, 2'b00);
        check("R2 carry 09->10", 4'd1, 4'd0, 1'b1, 1'b0);
        apply(4'b0010, 2'b00);
        check("R3 borrow 10->09", 4'd0, 4'd9, 1'b1, 1'b0);
        apply(4'b0100, 2'b00);
        apply(4'b0001, 2'b00);
        check("R4 start from 10", 4'd1, 4'd0, 1'b0, 1'b0);
        apply(4'b0000, 2'b10);
        check("R5 count 10->09", 4'd0, 4'd9, 1'b0, 1'b0);
        apply(4'b1000, 2'b00);
        check("R7 stop shows preset", 4'd1, 4'd0, 1'b1, 1'b0);

        // back to 01, then set on the final tick (R10)
        for (int i = 0; i < 9; i++) apply(4'b0010, 2'b00);
        apply(4'b0001, 2'b00);
        check("R4 start from 01", 4'd0, 4'd1, 1'b0, 1'b0);
        apply(4'b1000, 2'b10);
        check("R10 set beats final tick", 4'd0, 4'd1, 1'b1, 1'b0);

        // enter with up in the same cycle (R11)
        apply(4'b0101, 2'b00);
        check("R11 enter beats up", 4'd0, 4'd1, 1'b0, 1'b0);
        apply(4'b1000, 2'b00);
        check("R11 preset unchanged", 4'd0, 4'd1, 1'b1, 1'b0);

        // set while blanked (R7, R6)
        apply(4'b0001, 2'b00);
        apply(4'b0000, 2'b10);
        apply(4'b0000, 2'b01);
        check("R6 blanked in expiry", 4'd0, 4'd0, 1'b0, 1'b1);
        apply(4'b0000, 2'b10);
        check("R6 stays expired", 4'd0, 4'd0, 1'b0, 1'b1);
        apply(4'b1000, 2'b00);
        check("R7 set clears blank", 4'd0, 4'd1, 1'b1, 1'b0);

        // reset during a count (R1)
        apply(4'b0100, 2'b00);
        apply(4'b0001, 2'b00);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset mid-count", 4'd0, 4'd1, 1'b1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule